// File: doc/BRIEF.md
# Piecewise ADC-to-Temperature Converter

This block turns a 10-bit ADC reading into a signed temperature in millidegrees Celsius. It has two conversion modes, chosen per sample. In thermistor mode, the code is compared against four breakpoints. This picks one of five straight-line segments. Each segment subtracts a truncated quotient of the code from a fixed offset. In direct (die) mode, a single gain-and-offset formula with truncating division is used instead. Each mode has its own window of acceptable codes. A code outside that window raises an error flag and does not produce a new temperature.

A sample is offered with a one-cycle strobe, and a new sample may be offered on every cycle. The result, the error flag and an output strobe appear together two clock edges later. The division by constants is done with reciprocal multiply-and-shift logic. Each reciprocal is sized so that the quotient is exact for every input code. After an error, the temperature output keeps the last good value.

Top module: `therm_code_conv`

## Requirements
- R1: While reset is asserted and after it is released with no input strobe, `out_valid`, `out_err` and `out_temp` are all zero.
- R2: A strobe on `in_valid` captured at clock edge N produces a one-cycle `out_valid` after edge N+2. Strobes on consecutive cycles produce results on consecutive cycles, in the same order.
- R3: In thermistor mode (`in_direct`=0), codes below 162 or above 977 set `out_err` together with `out_valid`.
- R4: In thermistor mode, for codes 888..977 the temperature is 177 − floor(code/5) °C. For codes 721..887 it is 111 − floor(code/8) °C.
- R5: In thermistor mode, for codes 509..720 the temperature is 92 − floor(code/10) °C. For codes 316..508 it is 91 − floor(code/10) °C.
- R6: In thermistor mode, for codes 162..315 the temperature is 112 − floor(code/6) °C.
- R7: In direct mode (`in_direct`=1), codes 488..1004 give floor(368·code/1000) − 220 °C. Any other code sets `out_err`.
- R8: `out_temp` is the whole-degree result times 1000, as 32-bit two's complement. For example, code 977 in thermistor mode gives −18000.
- R9: `out_err` is high only while `out_valid` is high. On an error, `out_temp` keeps the last good temperature.
- R10: While no strobe arrives, `out_valid` stays low and `out_temp` does not change, whatever `in_code` and `in_direct` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_direct | input | 1 | 1 = direct die formula, 0 = thermistor segments |
| in_code | input | 10 | ADC code |
| out_valid | output | 1 | Result strobe, two edges after `in_valid` |
| out_err | output | 1 | Code was outside the window for its mode |
| out_temp | output | 32 | Temperature in millidegrees Celsius, signed |

## Verification
The latency and range properties assume that `in_code` and `in_direct` are meaningful only in the cycle where `in_valid` is high. They also assume that `in_valid` is a clean level, sampled once per edge and never X after reset. The bench drives every input on the falling edge and returns `in_valid` to zero between isolated conversions. It only changes `in_code` and `in_direct` freely while the strobe is low, which is exactly the pattern R10 tests. Streaming checks keep the strobe high for several edges in a row, so the two-stage pipeline is tested at full throughput as well as one sample at a time.

// File: rtl/therm_conv_pkg.sv
package therm_conv_pkg;

  // segment indices, highest code first
  localparam int NUM_SEG    = 5;
  localparam int SEG_TOP    = 0;
  localparam int SEG_UPPER  = 1;
  localparam int SEG_MID    = 2;
  localparam int SEG_LOWER  = 3;
  localparam int SEG_BOTTOM = 4;

  // thermistor window and breakpoints (a code above a breakpoint is in the higher segment)
  localparam int TH_MIN = 162;
  localparam int TH_MAX = 977;
  localparam int BP_0   = 887;
  localparam int BP_1   = 720;
  localparam int BP_2   = 508;
  localparam int BP_3   = 315;

  // die window and formula constants
  localparam int DIE_MIN  = 488;
  localparam int DIE_MAX  = 1004;
  localparam int DIE_GAIN = 368;
  localparam int DIE_DIV  = 1000;
  localparam int DIE_OFS  = 220;

  // divider slots shared between segments
  localparam int NUM_SLOT = 4;

  function automatic int slot_divisor(input int slot);
    case (slot)
      0:       return 5;
      1:       return 8;
      2:       return 10;
      default: return 6;
    endcase
  endfunction

  function automatic int seg_slot(input int seg);
    case (seg)
      SEG_TOP:   return 0;
      SEG_UPPER: return 1;
      SEG_MID:   return 2;
      SEG_LOWER: return 2;
      default:   return 3;
    endcase
  endfunction

  function automatic int seg_offset(input int seg);
    case (seg)
      SEG_TOP:   return 177;
      SEG_UPPER: return 111;
      SEG_MID:   return 92;
      SEG_LOWER: return 91;
      default:   return 112;
    endcase
  endfunction

  // reciprocal for multiply-shift division: ceil(2^shift / d)
  function automatic longint unsigned recip(input int d, input int shift);
    longint unsigned one;
    one = longint'(1) << shift;
    return (one + longint'(d) - 1) / longint'(d);
  endfunction

endpackage

// File: rtl/tcc_const_div.sv
module tcc_const_div #(
  parameter int IN_W    = 10,
  parameter int OUT_W   = 10,
  parameter int DIVISOR = 5,
  parameter int SHIFT   = 14
) (
  input  logic [IN_W-1:0]  num,
  output logic [OUT_W-1:0] quo
);
  import therm_conv_pkg::*;

  // SHIFT is chosen so that num_max * (MUL*DIVISOR - 2^SHIFT) < 2^SHIFT, which makes the quotient exact
  localparam int              PROD_W = IN_W + SHIFT;
  localparam longint unsigned MUL    = recip(DIVISOR, SHIFT);

  assign quo = OUT_W'((PROD_W'(num) * PROD_W'(MUL)) >> SHIFT);

endmodule

// File: rtl/tcc_seg_pick.sv
module tcc_seg_pick
  import therm_conv_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int DEG_W  = 12
) (
  input  logic [CODE_W-1:0]       code,
  input  logic                    direct,
  output logic [NUM_SEG-1:0]      seg_hit,
  output logic                    in_range,
  output logic signed [DEG_W-1:0] deg
);
  localparam int TH_SHIFT  = CODE_W + 4;
  localparam int GAIN_W    = 9;
  localparam int DIE_NUM_W = CODE_W + GAIN_W;
  localparam int DIE_SHIFT = DIE_NUM_W + 10;

  // one exact divider per distinct thermistor divisor
  logic [CODE_W-1:0] q [NUM_SLOT];
  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_div
    tcc_const_div #(
      .IN_W(CODE_W), .OUT_W(CODE_W),
      .DIVISOR(slot_divisor(g)), .SHIFT(TH_SHIFT)
    ) u_div (
      .num(code), .quo(q[g])
    );
  end

  // direct path: gain then divide
  logic [DIE_NUM_W-1:0] die_num;
  logic [CODE_W-1:0]    die_q;
  assign die_num = DIE_NUM_W'(code) * DIE_NUM_W'(DIE_GAIN);

  tcc_const_div #(
    .IN_W(DIE_NUM_W), .OUT_W(CODE_W),
    .DIVISOR(DIE_DIV), .SHIFT(DIE_SHIFT)
  ) u_die (
    .num(die_num), .quo(die_q)
  );

  // segment decode
  always_comb begin
    seg_hit[SEG_TOP]    = code > CODE_W'(BP_0);
    seg_hit[SEG_UPPER]  = (code > CODE_W'(BP_1)) && (code <= CODE_W'(BP_0));
    seg_hit[SEG_MID]    = (code > CODE_W'(BP_2)) && (code <= CODE_W'(BP_1));
    seg_hit[SEG_LOWER]  = (code > CODE_W'(BP_3)) && (code <= CODE_W'(BP_2));
    seg_hit[SEG_BOTTOM] = code <= CODE_W'(BP_3);
  end

  int seg_sel;
  always_comb begin
    seg_sel = SEG_BOTTOM;
    for (int s = NUM_SEG - 1; s >= 0; s--) begin
      if (seg_hit[s]) seg_sel = s;
    end
  end

  logic th_ok, die_ok;
  assign th_ok  = (code >= CODE_W'(TH_MIN))  && (code <= CODE_W'(TH_MAX));
  assign die_ok = (code >= CODE_W'(DIE_MIN)) && (code <= CODE_W'(DIE_MAX));
  assign in_range = direct ? die_ok : th_ok;

  logic signed [DEG_W-1:0] th_deg, die_deg;
  always_comb begin
    th_deg  = DEG_W'(seg_offset(seg_sel)) - DEG_W'(q[seg_slot(seg_sel)]);
    die_deg = DEG_W'(die_q) - DEG_W'(DIE_OFS);
    deg     = direct ? die_deg : th_deg;
  end

endmodule

// File: rtl/tcc_mdeg_scale.sv
module tcc_mdeg_scale #(
  parameter int DEG_W  = 12,
  parameter int TEMP_W = 32
) (
  input  logic signed [DEG_W-1:0]  deg,
  output logic signed [TEMP_W-1:0] mdeg
);
  logic signed [TEMP_W-1:0] ext;
  assign ext  = {{(TEMP_W-DEG_W){deg[DEG_W-1]}}, deg};
  // x * 1000 = x*1024 - x*16 - x*8
  assign mdeg = (ext <<< 10) - (ext <<< 4) - (ext <<< 3);
endmodule

// File: rtl/therm_code_conv.sv
module therm_code_conv
  import therm_conv_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int TEMP_W = 32,
  parameter int DEG_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_direct,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic              out_err,
  output logic [TEMP_W-1:0] out_temp
);
  // stage 0: combinational segment pick and degree computation
  logic [NUM_SEG-1:0]      seg_hit;
  logic                    code_ok;
  logic signed [DEG_W-1:0] deg_c;

  tcc_seg_pick #(.CODE_W(CODE_W), .DEG_W(DEG_W)) u_pick (
    .code(in_code), .direct(in_direct),
    .seg_hit(seg_hit), .in_range(code_ok), .deg(deg_c)
  );

  // stage 1 registers
  logic                    s1_valid, s1_err;
  logic signed [DEG_W-1:0] s1_deg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_err   <= 1'b0;
      s1_deg   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_err   <= in_valid && !code_ok;
      if (in_valid) s1_deg <= deg_c;
    end
  end

  // stage 2: scale to millidegrees, update only on good result
  logic signed [TEMP_W-1:0] mdeg_c;
  logic                     take_result;

  tcc_mdeg_scale #(.DEG_W(DEG_W), .TEMP_W(TEMP_W)) u_scale (
    .deg(s1_deg), .mdeg(mdeg_c)
  );

  assign take_result = s1_valid && !s1_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_temp  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_err   <= s1_err;
      if (take_result) out_temp <= mdeg_c;
    end
  end

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker
  import therm_conv_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int TEMP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_direct,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic              out_err,
  input logic [TEMP_W-1:0] out_temp,
  input logic [NUM_SEG-1:0] seg_hit
);
  logic th_bad, die_bad;
  assign th_bad  = !in_direct && ((in_code < CODE_W'(TH_MIN)) || (in_code > CODE_W'(TH_MAX)));
  assign die_bad = in_direct && ((in_code < CODE_W'(DIE_MIN)) || (in_code > CODE_W'(DIE_MAX)));

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid); // R10
  AST_THERM_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && th_bad) |=> ##1 out_err); // R3
  AST_DIE_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && die_bad) |=> ##1 out_err); // R7
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid); // R9
  AST_ERR_HOLDS_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> $stable(out_temp)); // R9
  AST_IDLE_HOLDS_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_temp)); // R10
  AST_ONE_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_hit) == 1); // R4
endmodule

bind therm_code_conv tcc_checker #(.CODE_W(CODE_W), .TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_direct(in_direct),
  .in_code(in_code), .out_valid(out_valid), .out_err(out_err),
  .out_temp(out_temp), .seg_hit(seg_hit)
);

// File: tb/sim_therm_code_conv.sv
module sim_therm_code_conv;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_direct = 1'b0;
  logic [9:0]  in_code = '0;
  logic        out_valid, out_err;
  logic [31:0] out_temp;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int last_good = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  therm_code_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_direct(in_direct),
    .in_code(in_code), .out_valid(out_valid), .out_err(out_err), .out_temp(out_temp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference written as plain integer arithmetic
  function automatic int ref_deg(input int c, input bit d, output bit ok);
    if (d) begin
      ok = (c >= 488) && (c <= 1004);
      return (c * 368) / 1000 - 220;
    end
    ok = (c >= 162) && (c <= 977);
    if (c >= 888) return 177 - c / 5;
    if (c >= 721) return 111 - c / 8;
    if (c >= 509) return 92 - c / 10;
    if (c >= 316) return 91 - c / 10;
    return 112 - c / 6;
  endfunction

  function automatic string req_of(input int c, input bit d);
    if (d) return "R7";
    if (c < 162 || c > 977) return "R3";
    if (c >= 721) return "R4";
    if (c >= 316) return "R5";
    return "R6";
  endfunction

  task automatic convert(input int c, input bit d);
    bit ok;
    int dg;
    string rq;
    dg = ref_deg(c, d, ok);
    rq = req_of(c, d);
    @(negedge clk);
    in_valid = 1'b1; in_code = 10'(c); in_direct = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b0, "R2", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid === 1'b1, "R2", int'(out_valid), 1);
    chk(out_err === !ok, ok ? rq : "R9", int'(out_err), int'(!ok));
    if (ok) last_good = dg * 1000;
    chk($signed(out_temp) == last_good, ok ? rq : "R9", int'($signed(out_temp)), last_good);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_err === 1'b0 && out_temp === 32'd0, "R1", int'(out_temp), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0 && out_err === 1'b0 && out_temp === 32'd0, "R1", int'(out_temp), 0);
  endtask

  task automatic t_corners;
    int th [12] = '{161, 162, 315, 316, 508, 509, 720, 721, 887, 888, 977, 978};
    int di [6]  = '{0, 487, 488, 1004, 1005, 1023};
    foreach (th[i]) convert(th[i], 1'b0);
    foreach (di[i]) convert(di[i], 1'b1);
    convert(977, 1'b0);
    chk(out_temp === 32'hFFFF_B9B0, "R8", int'($signed(out_temp)), -18000);
    convert(488, 1'b1);
    chk($signed(out_temp) == -41000, "R8", int'($signed(out_temp)), -41000);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 1024; c++) convert(c, m[0]);
    end
  endtask

  task automatic t_err_hold;
    convert(600, 1'b0);
    convert(40, 1'b0);     // R9 held through thermistor error
    convert(1010, 1'b1);   // R9 held through die error
    chk(out_valid === 1'b1 && out_err === 1'b1, "R9", int'(out_err), 1);
  endtask

  task automatic t_stream;
    int cs [6] = '{170, 400, 600, 800, 950, 300};
    int ex [6];
    bit ok;
    foreach (cs[i]) ex[i] = ref_deg(cs[i], 1'b0, ok) * 1000;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk(out_valid === 1'b1, "R2", int'(out_valid), 1);
        chk($signed(out_temp) == ex[i-2], "R2", int'($signed(out_temp)), ex[i-2]);
      end
      if (i < 6) begin
        in_valid = 1'b1; in_code = 10'(cs[i]); in_direct = 1'b0;
      end else begin
        in_valid = 1'b0;
      end
    end
    last_good = ex[5];
    @(negedge clk);
    chk(out_valid === 1'b0, "R2", int'(out_valid), 0);
  endtask

  task automatic t_idle;
    int held;
    convert(250, 1'b0);
    held = int'($signed(out_temp));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_code = 10'(i * 200 + 3); in_direct = i[0];
      chk(out_valid === 1'b0, "R10", int'(out_valid), 0);
      chk($signed(out_temp) == held, "R10", int'($signed(out_temp)), held);
    end
  endtask

  initial begin
    t_reset();
    t_corners();
    t_err_hold();
    t_stream();
    t_idle();
    t_sweep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule